// File: doc/BRIEF.md
# Multi-Mode Receive Status Register

This block holds the receive status flags for a serial receiver that works in one of three modes: asynchronous, byte-synchronous, or bit-synchronous (flag-delimited frames). The receive datapath sends single-cycle event pulses. The block turns them into sticky status bits. What each bit means, and whether it can be set at all, depends on the mode selected. A CPU clears bits by writing a 1 to their positions.

In bit-synchronous mode, an abort or residual-bit ending also forces the end-of-message bit in the same cycle. The residual-bit event is taken from one of two datapath pulses, chosen by a configuration bit that says whether the CRC covers the data field. A load strobe in bit-synchronous mode copies the status into a frame status register and empties the status register in the same cycle. A receiver-reset input clears both registers.

Top module: `rx_stat_reg`

## Requirements
- R1: After `rst_n` is released, and one cycle after `rx_reset` is high, `status` and `fst` read 0x00. `rx_reset` overrides every event, write and load in the same cycle.
- R2: When `wr_en` is high, each 1 in `wr_data` clears the matching status bit one cycle later. Bits written with 0 keep their value.
- R3: If an event sets a bit in the same cycle that a write clears it, the bit reads 1 afterwards.
- R4: In bit-synchronous mode (`mode`=2'b10), `ev_abort` sets bit 5 and bit 7 together. Outside that mode, bit 5 reads 0 and `ev_abort` is ignored.
- R5: In asynchronous mode (`mode`=2'b00), `ev_frame_err` sets bit 4. The bit stays 1 until a write-1 clear or a receiver reset.
- R6: In bit-synchronous mode, bit 4 is the residual-bit flag, and setting it also sets bit 7. When `crc_inc_data`=1 the flag is set by `ev_resid_info`. When `crc_inc_data`=0 it is set by `ev_resid_fcs`. The other pulse is ignored.
- R7: In byte-synchronous mode (`mode`=2'b01, and also 2'b11), bits 4 and 5 read 0. Framing, abort and residual pulses, and writes to those bits, have no visible effect.
- R8: `ev_overrun` sets bit 3 in every mode.
- R9: `ev_crc_err` sets bit 2 only in the two synchronous modes. In asynchronous mode the pulse is ignored and bit 2 reads 0.
- R10: `ev_eom` sets bit 7 in every mode.
- R11: In bit-synchronous mode, `fst_load` copies the current `status` into `fst` and clears `status`. Events in that same cycle land in the emptied register. `fst` keeps its value until the next such load or a reset.
- R12: `fst_load` outside bit-synchronous mode changes neither `status` nor `fst`.
- R13: Bits 6, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_reset | input | 1 | Synchronous receiver reset; clears status and fst |
| mode | input | 2 | 00 asynchronous, 01 byte-synchronous, 10 bit-synchronous, 11 as 01 |
| crc_inc_data | input | 1 | Residual source select: 1 data-field pulse, 0 check-sequence pulse |
| ev_eom | input | 1 | End-of-message pulse |
| ev_abort | input | 1 | Abort-terminated frame pulse |
| ev_resid_info | input | 1 | Residual bits on last data-field character |
| ev_resid_fcs | input | 1 | Residual bits on last check-sequence character |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_overrun | input | 1 | Overrun pulse |
| ev_crc_err | input | 1 | CRC mismatch pulse |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | Write-1-to-clear mask |
| fst_load | input | 1 | Transfer strobe into the frame status register |
| status | output | 8 | Status bits: 7 EOM, 5 abort, 4 framing/residual, 3 overrun, 2 CRC |
| fst | output | 8 | Frame status register |

## Verification
The bench targets the cycle where a set and a write-1 clear collide. A design that lets the clear win would lose the event. It swaps the residual source select. A design that wires it backwards would flag residual frames from the wrong pulse or miss the forced end-of-message bit. The bench also fires load strobes that carry events of their own. A design that clears after setting would drop those events, and one that honours loads outside bit-synchronous mode would wipe status the CPU has not yet read. A long pseudo-random run, with mode switches and receiver resets, is compared against a cycle model built from the requirements.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int SW = 8;

  localparam int B_EOM = 7;
  localparam int B_ABT = 5;
  localparam int B_SHR = 4;
  localparam int B_OVR = 3;
  localparam int B_CRC = 2;

  typedef enum logic [1:0] {
    RXM_ASYNC = 2'b00,
    RXM_BYTE  = 2'b01,
    RXM_BIT   = 2'b10,
    RXM_RSVD  = 2'b11
  } rx_mode_e;

  // Bits that exist (are readable and clearable) in a given mode.
  function automatic logic [SW-1:0] live_mask(rx_mode_e m);
    logic [SW-1:0] v;
    v = '0;
    v[B_EOM] = 1'b1;
    v[B_OVR] = 1'b1;
    unique case (m)
      RXM_ASYNC: v[B_SHR] = 1'b1;
      RXM_BIT: begin
        v[B_ABT] = 1'b1;
        v[B_SHR] = 1'b1;
        v[B_CRC] = 1'b1;
      end
      default: v[B_CRC] = 1'b1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxs_set_decode.sv
module rxs_set_decode
  import rxs_pkg::*;
(
  input  rx_mode_e      mode,
  input  logic          crc_inc_data,
  input  logic          ev_eom,
  input  logic          ev_abort,
  input  logic          ev_resid_info,
  input  logic          ev_resid_fcs,
  input  logic          ev_frame_err,
  input  logic          ev_overrun,
  input  logic          ev_crc_err,
  output logic [SW-1:0] set_vec
);
  logic is_bit;
  logic is_async;
  logic resid_hit;
  logic abort_hit;

  always_comb begin
    is_bit    = (mode == RXM_BIT);
    is_async  = (mode == RXM_ASYNC);
    resid_hit = is_bit && (crc_inc_data ? ev_resid_info : ev_resid_fcs);
    abort_hit = is_bit && ev_abort;

    set_vec        = '0;
    set_vec[B_OVR] = ev_overrun;
    set_vec[B_CRC] = ev_crc_err && !is_async;
    set_vec[B_ABT] = abort_hit;
    set_vec[B_SHR] = resid_hit || (is_async && ev_frame_err);
    set_vec[B_EOM] = ev_eom || abort_hit || resid_hit;
  end
endmodule

// File: rtl/rxs_stat_core.sv
module rxs_stat_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_reset,
  input  logic         flush,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = rx_reset || flush || set_vec[i] || clr_vec[i];
      if (rx_reset)   bit_d = 1'b0;
      else if (flush) bit_d = set_vec[i];
      else            bit_d = set_vec[i] || (bit_q && !clr_vec[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign q[i] = bit_q;
  end
endmodule

// File: rtl/rxs_frame_hold.sv
module rxs_frame_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_reset,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         hold_en;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_en = rx_reset || load;
    hold_d  = rx_reset ? '0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (hold_en) q <= hold_d;
  end
endmodule

// File: rtl/rx_stat_reg.sv
module rx_stat_reg
  import rxs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_reset,
  input  logic [1:0]    mode,
  input  logic          crc_inc_data,
  input  logic          ev_eom,
  input  logic          ev_abort,
  input  logic          ev_resid_info,
  input  logic          ev_resid_fcs,
  input  logic          ev_frame_err,
  input  logic          ev_overrun,
  input  logic          ev_crc_err,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  input  logic          fst_load,
  output logic [SW-1:0] status,
  output logic [SW-1:0] fst
);
  rx_mode_e      mode_e;
  logic          rst_core_n;
  logic [SW-1:0] live;
  logic [SW-1:0] set_vec;
  logic [SW-1:0] clr_vec;
  logic [SW-1:0] core_q;
  logic          flush;

  always_comb begin
    mode_e  = rx_mode_e'(mode);
    live    = live_mask(mode_e);
    clr_vec = wr_en ? (wr_data & live) : '0;
    flush   = fst_load && (mode_e == RXM_BIT);
    status  = core_q & live;
  end

  rxs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rxs_set_decode u_dec (
    .mode          (mode_e),
    .crc_inc_data  (crc_inc_data),
    .ev_eom        (ev_eom),
    .ev_abort      (ev_abort),
    .ev_resid_info (ev_resid_info),
    .ev_resid_fcs  (ev_resid_fcs),
    .ev_frame_err  (ev_frame_err),
    .ev_overrun    (ev_overrun),
    .ev_crc_err    (ev_crc_err),
    .set_vec       (set_vec)
  );

  rxs_stat_core #(.W(SW)) u_core (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rx_reset (rx_reset),
    .flush    (flush),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .q        (core_q)
  );

  rxs_frame_hold #(.W(SW)) u_fst (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rx_reset (rx_reset),
    .load     (flush),
    .d        (status),
    .q        (fst)
  );
endmodule

module rx_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_reset,
  input logic [1:0] mode,
  input logic       ev_abort,
  input logic       ev_overrun,
  input logic       fst_load,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] status,
  input logic [7:0] fst
);
  // R1
  rxreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (status == 8'h00) && (fst == 8'h00));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_reset && ev_overrun) |=> status[3]);

  // R4
  abort_eom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_reset && mode == 2'b10 && ev_abort) |=> (mode != 2'b10 || (status[7] && status[5])));

  // R5
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && status[4] && !rx_reset && !(wr_en && wr_data[4]))
      |=> (mode != 2'b00 || status[4]));

  // R7
  byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[0] |-> (status[5:4] == 2'b00));

  // R9
  async_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !status[2]);

  // R11
  fst_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_reset && fst_load && mode == 2'b10) |=> (fst == $past(status)));

  // R12
  fst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_reset && !(fst_load && mode == 2'b10)) |=> $stable(fst));

  // R13
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] == 1'b0) && (status[1:0] == 2'b00));
endmodule

bind rx_stat_reg rx_stat_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .rx_reset   (rx_reset),
  .mode       (mode),
  .ev_abort   (ev_abort),
  .ev_overrun (ev_overrun),
  .fst_load   (fst_load),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .status     (status),
  .fst        (fst)
);

// File: tb/rx_stat_reg_bench.sv
`timescale 1ns/1ps
module rx_stat_reg_bench;
  logic       clk;
  logic       rst_n;
  logic       rx_reset;
  logic [1:0] mode;
  logic       crc_inc_data;
  logic       ev_eom, ev_abort, ev_resid_info, ev_resid_fcs;
  logic       ev_frame_err, ev_overrun, ev_crc_err;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       fst_load;
  logic [7:0] status;
  logic [7:0] fst;

  int n_chk = 0;
  int n_err = 0;

  rx_stat_reg u_rx_stat_reg (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .mode(mode),
    .crc_inc_data(crc_inc_data), .ev_eom(ev_eom), .ev_abort(ev_abort),
    .ev_resid_info(ev_resid_info), .ev_resid_fcs(ev_resid_fcs),
    .ev_frame_err(ev_frame_err), .ev_overrun(ev_overrun), .ev_crc_err(ev_crc_err),
    .wr_en(wr_en), .wr_data(wr_data), .fst_load(fst_load),
    .status(status), .fst(fst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_reset = 0; ev_eom = 0; ev_abort = 0; ev_resid_info = 0; ev_resid_fcs = 0;
    ev_frame_err = 0; ev_overrun = 0; ev_crc_err = 0; wr_en = 0; wr_data = 8'h00;
    fst_load = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wipe();
    rx_reset = 1;
    cyc();
  endtask

  // Cycle model from the requirements
  function automatic logic [7:0] mask_of(logic [1:0] m);
    case (m)
      2'b00:   return 8'h98;
      2'b10:   return 8'hBC;
      default: return 8'h8C;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  m_reg, m_fst, sets, live;
    logic [15:0] lf;
    idle();
    mode = 2'b00; crc_inc_data = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset fst", fst, 8'h00);

    // R10 / R2
    ev_eom = 1; cyc();
    chk("R10 eom async", status, 8'h80);
    wr_en = 1; wr_data = 8'h00; cyc();
    chk("R2 write zero keeps", status, 8'h80);
    wr_en = 1; wr_data = 8'h80; cyc();
    chk("R2 write one clears", status, 8'h00);

    // R5
    ev_frame_err = 1; cyc();
    chk("R5 framing set", status, 8'h10);
    repeat (3) cyc();
    chk("R5 framing sticky", status, 8'h10);
    wr_en = 1; wr_data = 8'h08; cyc();
    chk("R5 other-bit write keeps", status, 8'h10);
    wr_en = 1; wr_data = 8'h10; cyc();
    chk("R5 write clears", status, 8'h00);

    // R9 async
    ev_crc_err = 1; cyc();
    chk("R9 crc ignored async", status, 8'h00);
    // R4 outside bit mode
    ev_abort = 1; cyc();
    chk("R4 abort ignored async", status, 8'h00);

    // byte-sync
    mode = 2'b01; wipe();
    ev_overrun = 1; cyc();
    chk("R8 overrun byte", status, 8'h08);
    ev_crc_err = 1; cyc();
    chk("R9 crc byte", status, 8'h0C);
    ev_frame_err = 1; ev_abort = 1; ev_resid_info = 1; ev_resid_fcs = 1; cyc();
    chk("R7 byte quiet bits", status, 8'h0C);
    fst_load = 1; cyc();
    chk("R12 load ignored status", status, 8'h0C);
    chk("R12 load ignored fst", fst, 8'h00);

    // bit-sync
    mode = 2'b10; wipe();
    ev_abort = 1; cyc();
    chk("R4 abort forces eom", status, 8'hA0);
    wipe();
    crc_inc_data = 1;
    ev_resid_fcs = 1; cyc();
    chk("R6 fcs pulse ignored sel1", status, 8'h00);
    ev_resid_info = 1; cyc();
    chk("R6 info pulse sel1", status, 8'h90);
    wipe(); crc_inc_data = 0;
    ev_resid_info = 1; cyc();
    chk("R6 info pulse ignored sel0", status, 8'h00);
    ev_resid_fcs = 1; cyc();
    chk("R6 fcs pulse sel0", status, 8'h90);

    // R3
    wipe();
    ev_overrun = 1; cyc();
    ev_overrun = 1; wr_en = 1; wr_data = 8'h08; cyc();
    chk("R3 set beats clear", status, 8'h08);

    // R11
    wipe();
    ev_abort = 1; cyc();
    fst_load = 1; ev_overrun = 1; cyc();
    chk("R11 fst captures", fst, 8'hA0);
    chk("R11 status cleared plus new event", status, 8'h08);
    ev_crc_err = 1; cyc();
    chk("R11 fst holds", fst, 8'hA0);

    // R1 priority
    rx_reset = 1; ev_eom = 1; ev_overrun = 1; fst_load = 1; cyc();
    chk("R1 rx_reset status", status, 8'h00);
    chk("R1 rx_reset fst", fst, 8'h00);

    // Pseudo-random sweep against model (R2 R11 R13)
    m_reg = 8'h00; m_fst = 8'h00; lf = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 97 == 0) mode = (lf[1:0] == 2'b11) ? 2'b10 : lf[1:0];
      crc_inc_data = lf[9];
      ev_eom = lf[2] & lf[7]; ev_abort = lf[3] & lf[8]; ev_resid_info = lf[4] & lf[11];
      ev_resid_fcs = lf[5] & lf[12]; ev_frame_err = lf[6] & lf[13];
      ev_overrun = lf[0] & lf[14] & lf[3]; ev_crc_err = lf[1] & lf[15];
      wr_en = lf[10] & lf[2]; wr_data = {lf[7:4], lf[11:8]};
      fst_load = lf[12] & lf[6] & lf[0];
      rx_reset = (lf[15:11] == 5'h1F);
      live = mask_of(mode);
      sets = 8'h00;
      if (ev_eom) sets[7] = 1;
      if (ev_overrun) sets[3] = 1;
      if (ev_crc_err && mode != 2'b00) sets[2] = 1;
      if (mode == 2'b00 && ev_frame_err) sets[4] = 1;
      if (mode == 2'b10 && ev_abort) sets = sets | 8'hA0;
      if (mode == 2'b10 && (crc_inc_data ? ev_resid_info : ev_resid_fcs)) sets = sets | 8'h90;
      if (rx_reset) begin m_reg = 0; m_fst = 0; end
      else if (fst_load && mode == 2'b10) begin m_fst = m_reg & live; m_reg = sets; end
      else m_reg = (m_reg & ~(wr_en ? (wr_data & live) : 8'h00)) | sets;
      cyc();
      chk("R2 sweep status", status, m_reg & mask_of(mode));
      chk("R11 sweep fst", fst, m_fst);
      chk("R13 sweep unused", status & 8'h43, 8'h00);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule